// File: doc/BRIEF.md
# Prediction Stage Power-Aware Scheduler

This controller runs the prediction stage of a four-stage macroblock encoding pipeline (load, predict, and two later stages). Two prediction engines, one intra and one inter, share the stage. The controller starts them, watches their completion handshakes and drives a clock enable for each engine. When an engine has no work left, its clock enable goes low at once.

A start request latches the execution style for the whole macroblock. In separate execution only the chosen engine runs, and the other keeps its clock enable low. In mixed execution both engines start in the same cycle. The intra engine usually finishes first. Its result is then written into a shared transform interface buffer, which is marked valid, and the intra clock enable is dropped while the inter engine keeps working. The stage completes when every engine that was needed has reported done. In mixed execution the buffer is invalidated at that point, so that it can take the inter path's transformed data.

Top module: `pred_stage_sched`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the controller to idle from the next cycle. In idle both clock enables are low, `buf_valid_o` is low and no start, write, invalidate or stage-done pulse is driven.
- R2: Separate execution is selected by `mode_mixed_i`=0. In that case `sel_inter_i`=1 picks the inter engine and `sel_inter_i`=0 picks the intra engine. The other engine gets no start pulse, and its clock enable stays low for the whole macroblock.
- R3: A start request is taken while the controller is idle. In the cycle after that, each engine that is needed gets a one-cycle start pulse. In mixed execution (`mode_mixed_i`=1) both start pulses occur in that same cycle.
- R4: In mixed execution, `buf_wr_o` is high in the cycle in which the first intra done is presented. `buf_valid_o` is high from the next cycle until the stage completes.
- R5: In mixed execution the intra clock enable goes low in the cycle after intra done is sampled, while the inter clock enable stays high until inter done is sampled.
- R6: The stage completes in the cycle after the last required done is sampled. In mixed execution, that cycle also carries a one-cycle `buf_inval_o` pulse, and `buf_valid_o` is low in it.
- R7: If inter done arrives before intra done in mixed execution, completion waits until intra done has been sampled.
- R8: `mode_mixed_i` and `sel_inter_i` are sampled only when a start is accepted. Changes to them during a macroblock have no effect on that macroblock.
- R9: `stage_done_o` is high for exactly one cycle. A start request presented during that cycle is ignored. A start request presented in the following cycle is accepted.
- R10: A done pulse from an engine that is not running, or a repeated done pulse from an engine that has already finished, has no effect.
- R11: The clock enable of each needed engine is high from its start cycle through the cycle in which its done is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to run the prediction stage for one macroblock |
| mode_mixed_i | input | 1 | 1 = mixed execution, 0 = separate execution |
| sel_inter_i | input | 1 | Engine choice in separate execution: 1 = inter, 0 = intra |
| intra_done_i | input | 1 | Intra engine completion pulse |
| inter_done_i | input | 1 | Inter engine completion pulse |
| intra_start_o | output | 1 | Intra engine start pulse |
| inter_start_o | output | 1 | Inter engine start pulse |
| intra_clk_en_o | output | 1 | Intra engine clock enable |
| inter_clk_en_o | output | 1 | Inter engine clock enable |
| buf_wr_o | output | 1 | Write strobe that stores the intra result into the shared buffer |
| buf_valid_o | output | 1 | Shared buffer holds a valid intra result |
| buf_inval_o | output | 1 | One-cycle invalidate of the shared buffer |
| stage_done_o | output | 1 | One-cycle stage completion pulse |

## Verification
Macroblocks are run in both execution styles and with both engine choices. Engine latencies are drawn at random, which covers intra finishing first (the normal case), inter finishing first (this separates waiting on both engines from finishing on the first done) and both finishing in the same cycle (this separates a write followed by an immediate invalidate from a skipped write). Some runs toggle the mode inputs during the macroblock, to show that only the latched values matter. Some runs inject stray done pulses from an idle or already finished engine. Back-to-back starts, a start held through the completion cycle and a reset in the middle of a macroblock check the boundaries of the handshake.

// File: rtl/pred_sched_pkg.sv
package pred_sched_pkg;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_LAUNCH = 2'd1,
    PS_RUN    = 2'd2,
    PS_DONE   = 2'd3
  } ps_state_t;

  localparam int ENG_INTRA = 0;
  localparam int ENG_INTER = 1;
  localparam int NUM_ENG   = 2;

  // Whether engine idx takes part in a macroblock with the given style.
  function automatic logic eng_needed(logic mixed, logic pick_inter, int idx);
    logic picked;
    picked = (idx == ENG_INTER) ? pick_inter : !pick_inter;
    return mixed | picked;
  endfunction

  // Stage completes when every engine reports finished (or unneeded).
  function automatic logic all_finished(logic [NUM_ENG-1:0] fin);
    return &fin;
  endfunction

endpackage

// File: rtl/ps_seq.sv
module ps_seq
  import pred_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      mode_mixed_i,
  input  logic      sel_inter_i,
  input  logic      all_fin,
  output ps_state_t state_o,
  output logic      accept_o,
  output logic      launch_o,
  output logic      active_o,
  output logic      go_done_o,
  output logic      in_done_o,
  output logic      mixed_q_o,
  output logic      sel_q_o
);

  ps_state_t state_q;
  logic      mixed_q;
  logic      sel_q;

  assign accept_o  = (state_q == PS_IDLE) && start_i;
  assign launch_o  = (state_q == PS_LAUNCH);
  assign active_o  = (state_q == PS_LAUNCH) || (state_q == PS_RUN);
  assign go_done_o = active_o && all_fin;
  assign in_done_o = (state_q == PS_DONE);
  assign state_o   = state_q;
  assign mixed_q_o = mixed_q;
  assign sel_q_o   = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      mixed_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      unique case (state_q)
        PS_IDLE: begin
          if (start_i) begin
            state_q <= PS_LAUNCH;
            mixed_q <= mode_mixed_i;
            sel_q   <= sel_inter_i;
          end
        end
        PS_LAUNCH, PS_RUN: begin
          state_q <= all_fin ? PS_DONE : PS_RUN;
        end
        PS_DONE: state_q <= PS_IDLE;
        default: state_q <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ps_eng_track.sv
module ps_eng_track
  import pred_sched_pkg::*;
#(
  parameter int IDX = ENG_INTRA
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic launch,
  input  logic active,
  input  logic mixed_q,
  input  logic sel_q,
  input  logic done_i,
  output logic start_o,
  output logic clk_en_o,
  output logic fin_q_o,
  output logic fin_now_o
);

  logic need;
  logic fin_q;

  assign need      = eng_needed(mixed_q, sel_q, IDX);
  assign start_o   = launch && need;
  assign clk_en_o  = active && need && !fin_q;
  assign fin_now_o = !need || fin_q || (active && done_i);
  assign fin_q_o   = fin_q;

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      fin_q <= 1'b0;
    end else if (active && need && done_i) begin
      fin_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ps_buf_ctl.sv
module ps_buf_ctl (
  input  logic clk,
  input  logic rst,
  input  logic mixed_q,
  input  logic active,
  input  logic intra_done_i,
  input  logic intra_fin_q,
  input  logic go_done,
  input  logic in_done,
  output logic buf_wr_o,
  output logic buf_valid_o,
  output logic buf_inval_o
);

  logic valid_q;

  assign buf_wr_o    = mixed_q && active && intra_done_i && !intra_fin_q;
  assign buf_inval_o = in_done && mixed_q;
  assign buf_valid_o = valid_q;

  // Completion clears the buffer; it wins over a same-cycle write.
  always_ff @(posedge clk) begin
    if (rst || go_done) begin
      valid_q <= 1'b0;
    end else if (buf_wr_o) begin
      valid_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pred_stage_sched.sv
module pred_stage_sched
  import pred_sched_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic mode_mixed_i,
  input  logic sel_inter_i,
  input  logic intra_done_i,
  input  logic inter_done_i,
  output logic intra_start_o,
  output logic inter_start_o,
  output logic intra_clk_en_o,
  output logic inter_clk_en_o,
  output logic buf_wr_o,
  output logic buf_valid_o,
  output logic buf_inval_o,
  output logic stage_done_o
);

  ps_state_t          state;
  logic               accept, launch, active, go_done, in_done;
  logic               mixed_q, sel_q;
  logic [NUM_ENG-1:0] eng_done, eng_start, eng_en, eng_fin_q, eng_fin_now;
  logic               all_fin;

  assign eng_done[ENG_INTRA] = intra_done_i;
  assign eng_done[ENG_INTER] = inter_done_i;
  assign all_fin = all_finished(eng_fin_now);

  ps_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mode_mixed_i (mode_mixed_i),
    .sel_inter_i  (sel_inter_i),
    .all_fin      (all_fin),
    .state_o      (state),
    .accept_o     (accept),
    .launch_o     (launch),
    .active_o     (active),
    .go_done_o    (go_done),
    .in_done_o    (in_done),
    .mixed_q_o    (mixed_q),
    .sel_q_o      (sel_q)
  );

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    ps_eng_track #(.IDX(g)) u_trk (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .launch    (launch),
      .active    (active),
      .mixed_q   (mixed_q),
      .sel_q     (sel_q),
      .done_i    (eng_done[g]),
      .start_o   (eng_start[g]),
      .clk_en_o  (eng_en[g]),
      .fin_q_o   (eng_fin_q[g]),
      .fin_now_o (eng_fin_now[g])
    );
  end

  ps_buf_ctl u_buf (
    .clk          (clk),
    .rst          (rst),
    .mixed_q      (mixed_q),
    .active       (active),
    .intra_done_i (intra_done_i),
    .intra_fin_q  (eng_fin_q[ENG_INTRA]),
    .go_done      (go_done),
    .in_done      (in_done),
    .buf_wr_o     (buf_wr_o),
    .buf_valid_o  (buf_valid_o),
    .buf_inval_o  (buf_inval_o)
  );

  assign intra_start_o  = eng_start[ENG_INTRA];
  assign inter_start_o  = eng_start[ENG_INTER];
  assign intra_clk_en_o = eng_en[ENG_INTRA];
  assign inter_clk_en_o = eng_en[ENG_INTER];
  assign stage_done_o   = in_done;

endmodule

// File: rtl/pred_stage_sched_chk.sv
module pred_stage_sched_chk (
  input logic clk,
  input logic rst,
  input logic mixed_q,
  input logic intra_done_i,
  input logic inter_done_i,
  input logic intra_start_o,
  input logic inter_start_o,
  input logic intra_clk_en_o,
  input logic inter_clk_en_o,
  input logic buf_wr_o,
  input logic buf_valid_o,
  input logic buf_inval_o,
  input logic stage_done_o
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!intra_clk_en_o && !inter_clk_en_o && !buf_valid_o && !stage_done_o));

  assert_sep_one_engine_R2: assert property (@(posedge clk) disable iff (rst)
    (intra_clk_en_o && inter_clk_en_o) |-> mixed_q);

  assert_mixed_joint_start_R3: assert property (@(posedge clk) disable iff (rst)
    (mixed_q && intra_start_o) |-> inter_start_o);

  assert_write_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
    buf_wr_o |=> (buf_valid_o || stage_done_o));

  assert_intra_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (mixed_q && intra_done_i && intra_clk_en_o && inter_clk_en_o && !inter_done_i)
      |=> (!intra_clk_en_o && inter_clk_en_o));

  assert_inval_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    buf_inval_o |-> (stage_done_o && !buf_valid_o));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    stage_done_o |=> (!stage_done_o && !intra_start_o && !inter_start_o));

endmodule

bind pred_stage_sched pred_stage_sched_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .mixed_q        (mixed_q),
  .intra_done_i   (intra_done_i),
  .inter_done_i   (inter_done_i),
  .intra_start_o  (intra_start_o),
  .inter_start_o  (inter_start_o),
  .intra_clk_en_o (intra_clk_en_o),
  .inter_clk_en_o (inter_clk_en_o),
  .buf_wr_o       (buf_wr_o),
  .buf_valid_o    (buf_valid_o),
  .buf_inval_o    (buf_inval_o),
  .stage_done_o   (stage_done_o)
);

// File: tb/test_pred_stage_sched.sv
`timescale 1ns/1ps
module test_pred_stage_sched;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, mode_mixed_i = 1'b0, sel_inter_i = 1'b0;
  logic intra_done_i = 1'b0, inter_done_i = 1'b0;
  logic intra_start_o, inter_start_o, intra_clk_en_o, inter_clk_en_o;
  logic buf_wr_o, buf_valid_o, buf_inval_o, stage_done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic nx_mixed = 1'b0, nx_sel = 1'b0;

  always #2 clk = ~clk;

  pred_stage_sched i_pred_stage_sched (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_mixed_i(mode_mixed_i),
    .sel_inter_i(sel_inter_i), .intra_done_i(intra_done_i), .inter_done_i(inter_done_i),
    .intra_start_o(intra_start_o), .inter_start_o(inter_start_o),
    .intra_clk_en_o(intra_clk_en_o), .inter_clk_en_o(inter_clk_en_o),
    .buf_wr_o(buf_wr_o), .buf_valid_o(buf_valid_o), .buf_inval_o(buf_inval_o),
    .stage_done_o(stage_done_o)
  );

  function automatic bit need_of(bit mixed, bit pick_inter, bit is_inter);
    return mixed || (is_inter ? pick_inter : !pick_inter);
  endfunction

  // Completion cycle, counted from the start-pulse cycle (0).
  function automatic int done_cycle(bit mixed, bit pick_inter, int li, int le);
    int d = 0;
    if (need_of(mixed, pick_inter, 1'b0) && li > d) d = li;
    if (need_of(mixed, pick_inter, 1'b1) && le > d) d = le;
    return d + 1;
  endfunction

  task automatic chk(string req, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, "intra_start", intra_start_o, 1'b0);
    chk(req, "inter_start", inter_start_o, 1'b0);
    chk(req, "intra_en", intra_clk_en_o, 1'b0);
    chk(req, "inter_en", inter_clk_en_o, 1'b0);
    chk(req, "buf_valid", buf_valid_o, 1'b0);
    chk(req, "buf_inval", buf_inval_o, 1'b0);
    chk(req, "stage_done", stage_done_o, 1'b0);
  endtask

  // One macroblock. pre: start already driven by the previous call.
  task automatic run_mb(bit mixed, bit pick_inter, int li, int le, bit flip, bit noise,
                        bit hold, bit chain, bit pre, string tag);
    bit ni = need_of(mixed, pick_inter, 1'b0);
    bit ne = need_of(mixed, pick_inter, 1'b1);
    int d = done_cycle(mixed, pick_inter, li, le);
    if (!pre) begin
      @(negedge clk);
      start_i = 1'b1; mode_mixed_i = mixed; sel_inter_i = pick_inter;
    end
    for (int c = 0; c <= d + 1; c++) begin
      @(negedge clk);
      start_i = (hold && c == d) || (chain && c == d + 1);
      if (flip && c <= d) begin
        mode_mixed_i = 1'($urandom % 2);   // R8: must have no effect
        sel_inter_i  = 1'($urandom % 2);
      end
      if (chain && c == d + 1) begin
        mode_mixed_i = nx_mixed; sel_inter_i = nx_sel;
      end
      intra_done_i = ni ? (c == li || (noise && c > li && ($urandom % 3 == 0)))
                        : (noise && ($urandom % 3 == 0));   // R10
      inter_done_i = ne ? (c == le || (noise && c > le && ($urandom % 3 == 0)))
                        : (noise && ($urandom % 3 == 0));
      #0.5;
      chk({"R3 ", tag}, "intra_start", intra_start_o, ni && c == 0);
      chk({"R3 ", tag}, "inter_start", inter_start_o, ne && c == 0);
      chk({ni ? "R11 " : "R2 ", tag}, "intra_en", intra_clk_en_o, ni && c <= li);
      chk({ne ? "R5 " : "R2 ", tag}, "inter_en", inter_clk_en_o, ne && c <= le);
      chk({"R4 ", tag}, "buf_wr", buf_wr_o, mixed && c == li);
      chk({"R4 ", tag}, "buf_valid", buf_valid_o, mixed && c > li && c <= d - 1);
      chk({"R6 ", tag}, "buf_inval", buf_inval_o, mixed && c == d);
      chk({"R9 ", tag}, "stage_done", stage_done_o, c == d);
    end
    intra_done_i = 1'b0; inter_done_i = 1'b0;
    if (!chain) start_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2013));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #0.5;
    chk_idle("R1 after reset");

    // Directed corner cases.
    run_mb(1, 0, 3, 7, 0, 0, 0, 0, 0, "mixed intra first");
    run_mb(1, 0, 8, 2, 0, 0, 0, 0, 0, "R7 inter first");
    run_mb(1, 1, 4, 4, 0, 0, 0, 0, 0, "R7 same cycle");
    run_mb(0, 0, 5, 2, 0, 1, 0, 0, 0, "R2 intra only R10");
    run_mb(0, 1, 3, 6, 0, 1, 0, 0, 0, "R2 inter only R10");
    run_mb(1, 0, 2, 5, 1, 0, 0, 0, 0, "R8 mode toggling");
    run_mb(0, 1, 6, 4, 1, 1, 0, 0, 0, "R8 sep toggling");
    run_mb(1, 1, 1, 1, 0, 0, 1, 0, 0, "R9 start held in done");
    nx_mixed = 1'b1; nx_sel = 1'b0;
    run_mb(0, 0, 2, 9, 0, 0, 0, 1, 0, "R9 back to back a");
    run_mb(1, 0, 3, 5, 0, 0, 0, 0, 1, "R9 back to back b");

    // Reset in the middle of a macroblock.
    @(negedge clk);
    start_i = 1'b1; mode_mixed_i = 1'b1; sel_inter_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #0.5;
    chk_idle("R1 mid-run reset");
    @(negedge clk);
    #0.5;
    chk_idle("R1 stays idle");

    // Constrained random macroblocks.
    begin
      bit m, s, pre = 0;
      bit nm = 1'($urandom % 2), ns = 1'($urandom % 2);
      for (int i = 0; i < 60; i++) begin
        bit ch;
        m = nm; s = ns;
        nm = 1'($urandom % 2); ns = 1'($urandom % 2);
        nx_mixed = nm; nx_sel = ns;
        ch = (i < 59) && ($urandom % 2 == 1);
        run_mb(m, s, 1 + int'($urandom % 12), 1 + int'($urandom % 12),
               1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 4 == 0) && !ch,
               ch, pre, "random R8 R10");
        pre = ch;
      end
    end

    @(negedge clk);
    #0.5;
    chk_idle("R1 final idle");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule